// File: doc/BRIEF.md
# Crosswise Column-Stage Integer Multiplier

This block multiplies two unsigned N-bit operands and produces a 2N-bit product. It uses the vertical-and-crosswise scheme. For each output weight j, a sliding window pairs operand bits whose indices add up to j. The AND of each such pair becomes one partial product of that column.

Each column has its own reduction stage. The stage holds one or more 4:2 compressors in a chain, closed by one full adder. The stage reduces the column's partial products and the carries arriving from the column below to a single product bit. Its carries go on to the next column. There are 2N-1 stages, and the top product bit is formed from the carries that leave the last stage. A wider operand width only changes how many compressor and full-adder cells are placed and where they sit.

The combinational product is captured in an output register with a load enable. The register is cleared by an asynchronous active-low reset.

Top module: `vedic_mul`

## Requirements
- R1: When `en` is high at a rising clock edge, `p` holds `a*b` from that edge onward (one register stage of latency).
- R2: When `en` is low at a rising clock edge, `p` keeps its previous value whatever `a` and `b` do.
- R3: Driving `rst_n` low clears `p` to zero at once, without waiting for a clock edge, and `p` stays zero while reset is held.
- R4: Column j sums exactly the products a[i]&b[j-i] for every valid i. A single set bit at position i in `a` and at position k in `b` therefore yields a product with only bit i+k set.
- R5: All-ones operands, which fill every column to its largest partial-product count, give (2^N-1)^2.
- R6: Every compressor satisfies in1+in2+in3+in4+cin = sum + 2*(carry+cout), and every stage's output bit plus twice its outgoing carry count equals the number of ones it receives.
- R7: The most significant product bit is the OR of the carries leaving the last stage, and at most one of those carries is ever set. Examples: 15*15 at N=4 sets bit 7, and 8*15 leaves it clear.
- R8: With N=8 the same cells, added in greater number, give correct 16-bit products.
- R9: A zero in either operand gives a zero product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the product register |
| en | input | 1 | Load enable for the product register |
| a | input | N | Multiplicand, unsigned |
| b | input | N | Multiplier, unsigned |
| p | output | 2N | Registered product |

## Verification
The clocked checks assume `a`, `b` and `en` are known, stable values at every rising edge outside reset. The combinational count checks skip any cycle in which a stage input is unknown. The stimulus satisfies this by driving every input to a defined value from time zero, including during reset. It changes inputs only on falling edges, so each value is settled half a period before the edge that samples it. At N=4 every operand pair is applied, and the 8-bit instance receives one-hot, all-ones and random operands.

// File: rtl/vedic_pkg.sv
package vedic_pkg;

  // Number of crosswise partial products in output column j.
  function automatic int pp_cnt(int n, int j);
    if (j < 0 || j > 2*n-2) return 0;
    if (j < n) return j + 1;
    return 2*n - 1 - j;
  endfunction

  // Lowest index of operand a that falls in the window of column j.
  function automatic int win_lo(int n, int j);
    return (j - n + 1 > 0) ? j - n + 1 : 0;
  endfunction

  // Compressors in a stage that takes w bits (capacity 4K+3).
  function automatic int comp_cnt(int w);
    return (w / 4 < 1) ? 1 : w / 4;
  endfunction

  // Carries entering column j from column j-1.
  function automatic int cin_cnt(int n, int j);
    int c = 0;
    for (int k = 0; k < j; k++) begin
      c = 2 * comp_cnt(pp_cnt(n, k) + c) + 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/vedic_fa.sv
module vedic_fa (
  input  logic x,
  input  logic y,
  input  logic z,
  output logic s,
  output logic c
);
  assign s = x ^ y ^ z;
  assign c = (x & y) | (x & z) | (y & z);
endmodule

// File: rtl/vedic_comp42.sv
module vedic_comp42 (
  input  logic in1,
  input  logic in2,
  input  logic in3,
  input  logic in4,
  input  logic cin,
  output logic sum,
  output logic carry,
  output logic cout
);
  logic s1;

  vedic_fa u_upper (.x(in1), .y(in2), .z(in3), .s(s1),  .c(cout));
  vedic_fa u_lower (.x(s1),  .y(in4), .z(cin), .s(sum), .c(carry));

  always_comb begin
    if (!$isunknown({in1, in2, in3, in4, cin})) begin
      // R6
      comp_count_chk: assert ((int'(in1) + int'(in2) + int'(in3) + int'(in4) + int'(cin))
                              == (int'(sum) + 2 * (int'(carry) + int'(cout))));
    end
  end
endmodule

// File: rtl/vedic_stage.sv
module vedic_stage #(
  parameter int W_IN = 1,
  parameter int K    = 1
) (
  input  logic [W_IN-1:0]  bits,
  output logic             sum,
  output logic [2*K:0]     cy
);
  localparam int CAP = 4*K + 3;

  logic [CAP-1:0] pad;
  logic [K:0]     chain;

  always_comb begin
    pad = '0;
    pad[W_IN-1:0] = bits;
  end

  assign chain[0] = pad[0];

  for (genvar k = 0; k < K; k++) begin : cmp
    vedic_comp42 u_c42 (
      .in1  (chain[k]),
      .in2  (pad[4*k+1]),
      .in3  (pad[4*k+2]),
      .in4  (pad[4*k+3]),
      .cin  (pad[4*k+4]),
      .sum  (chain[k+1]),
      .carry(cy[K+k]),
      .cout (cy[k])
    );
  end

  vedic_fa u_close (
    .x(chain[K]),
    .y(pad[4*K+1]),
    .z(pad[4*K+2]),
    .s(sum),
    .c(cy[2*K])
  );

  always_comb begin
    if (!$isunknown(bits)) begin
      // R6
      stage_sum_chk: assert ($countones(bits) == int'(sum) + 2 * $countones(cy));
    end
  end
endmodule

// File: rtl/vedic_mul.sv
module vedic_mul #(
  parameter int N = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic [2*N-1:0] p
);
  import vedic_pkg::*;

  localparam int PW   = 2*N;
  localparam int NCOL = 2*N - 1;

  logic [PW-1:0] prod_c;
  logic [PW-1:0] p_d;
  logic [PW-1:0] p_q;

  for (genvar j = 0; j < NCOL; j++) begin : col
    localparam int PPC = pp_cnt(N, j);
    localparam int CI  = cin_cnt(N, j);
    localparam int W   = PPC + CI;
    localparam int K   = comp_cnt(W);
    localparam int LO  = win_lo(N, j);

    logic [W-1:0] bits;
    logic         s;
    logic [2*K:0] cy;

    for (genvar i = 0; i < PPC; i++) begin : pp
      assign bits[i] = a[LO+i] & b[j-LO-i];
    end

    if (j > 0) begin : cin
      assign bits[W-1:PPC] = col[j-1].cy;
    end

    vedic_stage #(.W_IN(W), .K(K)) u_stage (
      .bits(bits),
      .sum (s),
      .cy  (cy)
    );

    assign prod_c[j] = s;
  end

  assign prod_c[PW-1] = |col[NCOL-1].cy;

  always_comb begin
    p_d = p_q;
    if (en) p_d = prod_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) p_q <= '0;
    else        p_q <= p_d;
  end

  assign p = p_q;

  // R1
  p_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (p == PW'($past(a)) * PW'($past(b))));

  // R2
  p_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(p));

  // R7
  msb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(col[NCOL-1].cy));

  // R3
  rst_clear_chk: assert property (@(posedge clk)
    !rst_n |-> (p == '0));
endmodule

// File: tb/vedic_mul_test.sv
module vedic_mul_test;
  logic        clk;
  logic        rst_n;
  logic        en;
  logic [3:0]  a, b;
  logic [7:0]  p;
  logic [7:0]  wa, wb;
  logic [15:0] wp;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  vedic_mul #(.N(4)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .a(a), .b(b), .p(p)
  );

  vedic_mul #(.N(8)) uut_wide (
    .clk(clk), .rst_n(rst_n), .en(en), .a(wa), .b(wb), .p(wp)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] x, input logic [3:0] y,
                       input logic [7:0] wx, input logic [7:0] wy);
    @(negedge clk);
    a = x; b = y; wa = wx; wb = wy; en = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; en = 1'b1; a = 4'hF; b = 4'hF; wa = 8'hFF; wb = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R3 narrow held in reset", 32'(p), 32'd0);
    chk("R3 wide held in reset", 32'(wp), 32'd0);
    rst_n = 1'b1;
    apply(4'd13, 4'd11, 8'd200, 8'd3);
    chk("R1 after reset release", 32'(p), 32'd143);
    #5 rst_n = 1'b0;
    #1;
    chk("R3 async clear narrow", 32'(p), 32'd0);
    chk("R3 async clear wide", 32'(wp), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_exhaustive;
    for (int x = 0; x < 16; x++) begin
      for (int y = 0; y < 16; y++) begin
        apply(4'(x), 4'(y), 8'(x), 8'(y));
        // R6: any miscount inside a stage would break one of these products
        chk("R1 R6 exhaustive N=4", 32'(p), 32'(x * y));
      end
    end
  endtask

  task automatic t_onehot;
    for (int i = 0; i < 4; i++) begin
      for (int k = 0; k < 4; k++) begin
        apply(4'(1 << i), 4'(1 << k), 8'd0, 8'd0);
        chk("R4 single column N=4", 32'(p), 32'(1 << (i + k)));
      end
    end
    for (int i = 0; i < 8; i++) begin
      for (int k = 0; k < 8; k++) begin
        apply(4'd0, 4'd0, 8'(1 << i), 8'(1 << k));
        chk("R4 single column N=8", 32'(wp), 32'(1 << (i + k)));
      end
    end
  endtask

  task automatic t_allones;
    apply(4'hF, 4'hF, 8'hFF, 8'hFF);
    chk("R5 all ones N=4", 32'(p), 32'd225);
    chk("R5 all ones N=8", 32'(wp), 32'd65025);
  endtask

  task automatic t_msb;
    apply(4'd15, 4'd15, 8'd255, 8'd129);
    chk("R7 msb set N=4", 32'(p[7]), 32'd1);
    chk("R7 msb set N=8", 32'(wp[15]), 32'd1);
    apply(4'd8, 4'd15, 8'd128, 8'd255);
    chk("R7 msb clear N=4", 32'(p[7]), 32'd0);
    chk("R7 msb clear N=8", 32'(wp[15]), 32'd0);
    apply(4'd9, 4'd15, 8'd200, 8'd200);
    chk("R7 msb set 135", 32'(p[7]), 32'd1);
  endtask

  task automatic t_hold;
    apply(4'd7, 4'd9, 8'd77, 8'd99);
    chk("R1 load before hold", 32'(p), 32'd63);
    @(negedge clk);
    en = 1'b0; a = 4'hF; b = 4'hF; wa = 8'hFF; wb = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R2 hold narrow", 32'(p), 32'd63);
    chk("R2 hold wide", 32'(wp), 32'd7623);
  endtask

  task automatic t_zero;
    apply(4'd0, 4'd13, 8'd0, 8'd201);
    chk("R9 zero a N=4", 32'(p), 32'd0);
    chk("R9 zero a N=8", 32'(wp), 32'd0);
    apply(4'd11, 4'd0, 8'd250, 8'd0);
    chk("R9 zero b N=4", 32'(p), 32'd0);
    chk("R9 zero b N=8", 32'(wp), 32'd0);
  endtask

  task automatic t_wide_random;
    for (int r = 0; r < 300; r++) begin
      logic [7:0] x, y;
      x = 8'($urandom);
      y = 8'($urandom);
      apply(x[3:0], y[3:0], x, y);
      chk("R8 random N=8", 32'(wp), 32'(x) * 32'(y));
    end
  endtask

  initial begin
    t_reset();
    t_exhaustive();
    t_onehot();
    t_allones();
    t_msb();
    t_hold();
    t_zero();
    t_wide_random();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule